// File: doc/BRIEF.md
# Single-channel DMA transfer sequencer

This block is the sequencing engine of one DMA channel. For every peripheral request it accepts while enabled, it issues one element-move command. The command carries the RAM address, the peripheral address, the direction, the element width and whether a zero should also be written to the peripheral. A surrounding bus fabric carries out the actual data movement. The engine keeps the element count within the current block. It picks the next RAM address from an incrementing, fixed or peripheral-supplied source. At the end of each block it reloads, alternates buffers or stops, depending on the operating mode. It also raises a one-cycle interrupt at the half-block point or at the end of the block.

Software sets the channel up through a small write port. Select code 0 writes the control word. Code 1 writes the primary RAM start address and code 2 the secondary one. Code 3 writes the peripheral address. Code 4 writes the block count as N-1 for a block of N elements. Any write to the control word restarts the channel: it goes back to the primary buffer with its element count at zero. The current control word, including an enable bit that the channel may have cleared itself, is always visible on a read-back port.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control read-back is 0 and no command or interrupt is issued. The implemented control bits are 15, 14, 13, 12, 11, 5:4 and 1:0. Writing 0xFFFF reads back as 0xF833.
- R2: A request sampled at a clock edge while control bit 15 (enable) is 1 produces exactly one command, with cmd_valid high for the following cycle. Requests made while the channel is disabled produce nothing.
- R3: cmd_byte equals control bit 14 (1 = byte, 0 = 16-bit word). cmd_ram_to_per equals control bit 13 (1 = RAM to peripheral, 0 = peripheral to RAM). cmd_per_addr is the peripheral address register.
- R4: Control bits 5:4 select the RAM address. With 00 the address advances by 1 (byte) or 2 (word) after each element. With 01 it stays fixed. With 10 it is req_addr, sampled with the request. Code 11 behaves as 01.
- R5: cmd_null_per is 1 exactly when control bit 11 is 1 and bit 13 is 0.
- R6: With control bit 12 clear, irq pulses with the command for the Nth element of each block, where the count register holds N-1.
- R7: With control bit 12 set, irq pulses with the command for element floor(N/2) of each block, or with element 1 when N is 1, and not at the block end.
- R8: Control bits 1:0 = 00 (continuous, single buffer): after each block the RAM address reloads from the primary start address and the count restarts.
- R9: Mode 10 (continuous, alternating buffers): successive blocks start at the primary, secondary, primary, ... start addresses.
- R10: Mode 01 (one-shot): after the block's last element the channel clears its enable bit, and later requests are ignored.
- R11: Mode 11 (one-shot, alternating): one block from the primary buffer, then one from the secondary buffer, then the enable bit clears.
- R12: A control write restarts the block at the primary start address with zero elements moved, even in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 primary start, 2 secondary start, 3 peripheral address, 4 count |
| cfg_wdata | input | 16 | Write data |
| ctrl_rd | output | 16 | Current control word |
| req | input | 1 | Peripheral transfer request, one element per cycle high |
| req_addr | input | AW | Peripheral-supplied RAM address (mode 10) |
| cmd_valid | output | 1 | Element-move command valid |
| cmd_ram_to_per | output | 1 | Command direction |
| cmd_byte | output | 1 | Command element is a byte |
| cmd_ram_addr | output | AW | RAM address of the element |
| cmd_per_addr | output | PW | Peripheral address |
| cmd_null_per | output | 1 | Also write zero to the peripheral |
| irq | output | 1 | Half- or full-block interrupt pulse |

## Verification
The bench targets the block boundaries. These include one-element blocks, where the half point must fall on the only element, and the exact element on which the one-shot alternating mode stops after its secondary block. A design that tested the half point against the count register instead of the element number would fire one element late. A design that stopped after the first buffer would lose the secondary block. Restarts in the middle of a block and requests while the channel is disabled are mixed in with random configurations. A stale element counter or a leaked command would show up as a wrong address or a spurious cmd_valid. Null writes are tried in both directions, to catch a zero write that is not suppressed when RAM feeds the peripheral.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   // control word bit positions
   localparam int B_EN   = 15;
   localparam int B_SIZE = 14;
   localparam int B_DIR  = 13;
   localparam int B_HALF = 12;
   localparam int B_NULL = 11;
   localparam logic [15:0] CTRL_IMPL = 16'hF833;

   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_BUFA = 3'd1,
      SEL_BUFB = 3'd2,
      SEL_PER  = 3'd3,
      SEL_CNT  = 3'd4
   } cfg_sel_e;

   typedef enum logic [1:0] {
      AM_INC = 2'b00,
      AM_FIX = 2'b01,
      AM_PER = 2'b10,
      AM_RSV = 2'b11
   } amode_e;

   typedef struct packed {
      logic   en;
      logic   byte_sz;
      logic   ram_to_per;
      logic   half_irq;
      logic   null_wr;
      amode_e amode;
      logic   pingpong;
      logic   oneshot;
   } ctrl_t;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
   import dma_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int PW = 12,
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [2:0]    sel,
   input  logic [15:0]   wdata,
   input  logic          clr_en,
   output ctrl_t         ctrl,
   output logic [15:0]   ctrl_word,
   output logic          ctrl_wr,
   output logic [AW-1:0] start_a,
   output logic [AW-1:0] start_b,
   output logic [PW-1:0] per_addr,
   output logic [CW-1:0] count
);
   logic [15:0] raw;

   assign ctrl_wr = we && (sel == SEL_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw      <= '0;
         start_a  <= '0;
         start_b  <= '0;
         per_addr <= '0;
         count    <= '0;
      end else begin
         if (ctrl_wr)
            raw <= wdata & CTRL_IMPL;
         else if (clr_en)
            raw[B_EN] <= 1'b0;
         if (we && sel == SEL_BUFA) start_a  <= wdata[AW-1:0];
         if (we && sel == SEL_BUFB) start_b  <= wdata[AW-1:0];
         if (we && sel == SEL_PER)  per_addr <= wdata[PW-1:0];
         if (we && sel == SEL_CNT)  count    <= wdata[CW-1:0];
      end
   end

   assign ctrl_word = raw;

   always_comb begin
      ctrl.en         = raw[B_EN];
      ctrl.byte_sz    = raw[B_SIZE];
      ctrl.ram_to_per = raw[B_DIR];
      ctrl.half_irq   = raw[B_HALF];
      ctrl.null_wr    = raw[B_NULL];
      ctrl.amode      = amode_e'(raw[5:4]);
      ctrl.pingpong   = raw[1];
      ctrl.oneshot    = raw[0];
   end

   // R10
   en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !ctrl.en);
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          step,
   input  logic [CW-1:0] count,
   output logic          last,
   output logic          half_hit
);
   logic [CW-1:0] elem;
   logic [CW:0]   half_pt;
   logic [CW:0]   half_eff;

   always_comb begin
      half_pt  = ({1'b0, count} + (CW+1)'(1)) >> 1;
      half_eff = (half_pt == '0) ? (CW+1)'(1) : half_pt;
      last     = (elem == count);
      half_hit = (({1'b0, elem} + (CW+1)'(1)) == half_eff);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         elem <= '0;
      else if (step)
         elem <= last ? '0 : elem + CW'(1);
   end

   // R7
   half_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && half_hit && count != '0) |-> !last);
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
   import dma_seq_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          step,
   input  logic          blk_end,
   input  amode_e        amode,
   input  logic          byte_sz,
   input  logic          pingpong,
   input  logic [AW-1:0] start_a,
   input  logic [AW-1:0] start_b,
   output logic [AW-1:0] cur,
   output logic          buf_b
);
   logic          next_buf;
   logic [AW-1:0] stride;

   assign next_buf = pingpong & ~buf_b;
   assign stride   = byte_sz ? AW'(1) : AW'(2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur   <= '0;
         buf_b <= 1'b0;
      end else if (restart) begin
         cur   <= start_a;
         buf_b <= 1'b0;
      end else if (step && blk_end) begin
         cur   <= next_buf ? start_b : start_a;
         buf_b <= next_buf;
      end else if (step && amode == AM_INC) begin
         cur   <= cur + stride;
      end
   end

   // R4
   inc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blk_end && !restart && amode == AM_INC)
      |=> cur == $past(cur) + ($past(byte_sz) ? AW'(1) : AW'(2)));

   // R4
   fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blk_end && !restart && amode != AM_INC) |=> $stable(cur));

   // R9
   pp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && blk_end && !restart && pingpong) |=> buf_b != $past(buf_b));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int PW = 12,
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [15:0]   cfg_wdata,
   output logic [15:0]   ctrl_rd,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   output logic          cmd_valid,
   output logic          cmd_ram_to_per,
   output logic          cmd_byte,
   output logic [AW-1:0] cmd_ram_addr,
   output logic [PW-1:0] cmd_per_addr,
   output logic          cmd_null_per,
   output logic          irq
);
   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("dma_chan_seq: AW must be 2..16");
   end
   if (PW < 1 || PW > 16) begin : g_bad_pw
      $error("dma_chan_seq: PW must be 1..16");
   end
   if (CW < 1 || CW > 16) begin : g_bad_cw
      $error("dma_chan_seq: CW must be 1..16");
   end

   ctrl_t         ctrl;
   logic          ctrl_wr;
   logic [AW-1:0] start_a, start_b, cur;
   logic [PW-1:0] per_addr;
   logic [CW-1:0] count;
   logic          last, half_hit, buf_b;
   logic          go, stop;

   assign go   = req && ctrl.en && !ctrl_wr;
   assign stop = go && last && ctrl.oneshot && (!ctrl.pingpong || buf_b);

   dma_seq_regs #(.AW(AW), .PW(PW), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .clr_en(stop), .ctrl(ctrl), .ctrl_word(ctrl_rd), .ctrl_wr(ctrl_wr),
      .start_a(start_a), .start_b(start_b), .per_addr(per_addr), .count(count)
   );

   dma_seq_count #(.CW(CW)) u_count (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .step(go), .count(count),
      .last(last), .half_hit(half_hit)
   );

   dma_seq_addr #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .step(go), .blk_end(last),
      .amode(ctrl.amode), .byte_sz(ctrl.byte_sz), .pingpong(ctrl.pingpong),
      .start_a(start_a), .start_b(start_b), .cur(cur), .buf_b(buf_b)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid      <= 1'b0;
         cmd_ram_to_per <= 1'b0;
         cmd_byte       <= 1'b0;
         cmd_ram_addr   <= '0;
         cmd_per_addr   <= '0;
         cmd_null_per   <= 1'b0;
         irq            <= 1'b0;
      end else begin
         cmd_valid <= go;
         irq       <= go && (ctrl.half_irq ? half_hit : last);
         if (go) begin
            cmd_ram_to_per <= ctrl.ram_to_per;
            cmd_byte       <= ctrl.byte_sz;
            cmd_ram_addr   <= (ctrl.amode == AM_PER) ? req_addr : cur;
            cmd_per_addr   <= per_addr;
            cmd_null_per   <= ctrl.null_wr && !ctrl.ram_to_per;
         end
      end
   end

   // R2
   cmd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(req));

   // R5
   null_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_null_per |-> !cmd_ram_to_per);

   // R6
   irq_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cmd_valid);
endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] ctrl_rd;
   logic        req = 1'b0;
   logic [15:0] req_addr = '0;
   logic        cmd_valid, cmd_ram_to_per, cmd_byte, cmd_null_per, irq;
   logic [15:0] cmd_ram_addr;
   logic [11:0] cmd_per_addr;

   int n_chk = 0;
   int n_err = 0;

   // bench model of the channel
   int m_ctrl = 0, m_a = 0, m_b = 0, m_per = 0, m_cnt = 0;
   int m_addr = 0, m_elem = 0, m_buf = 0;

   always #10 clk = ~clk;

   dma_chan_seq u_dma_chan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd), .req(req), .req_addr(req_addr),
      .cmd_valid(cmd_valid), .cmd_ram_to_per(cmd_ram_to_per), .cmd_byte(cmd_byte),
      .cmd_ram_addr(cmd_ram_addr), .cmd_per_addr(cmd_per_addr),
      .cmd_null_per(cmd_null_per), .irq(irq)
   );

   task automatic chk(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic int half_point(int cnt);
      int hp = (cnt + 1) / 2;
      return (hp == 0) ? 1 : hp;
   endfunction

   task automatic wcfg(int sel, int data);
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(data);
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: begin m_ctrl = data & 16'hF833; m_elem = 0; m_buf = 0; m_addr = m_a; end
         1: m_a = data & 16'hFFFF;
         2: m_b = data & 16'hFFFF;
         3: m_per = data & 12'hFFF;
         4: m_cnt = data & 10'h3FF;
         default: ;
      endcase
   endtask

   task automatic cyc(int r, int ra, string ctx);
      int e_v, e_ram, e_irq, am, last, nb;
      e_v = 0; e_ram = 0; e_irq = 0;
      am = (m_ctrl >> 4) & 3;
      if (r != 0 && m_ctrl[15]) begin
         e_v   = 1;
         e_ram = (am == 2) ? (ra & 16'hFFFF) : m_addr;
         last  = (m_elem == m_cnt) ? 1 : 0;
         e_irq = m_ctrl[12] ? ((m_elem + 1 == half_point(m_cnt)) ? 1 : 0) : last;
         if (last != 0) begin
            nb = m_ctrl[1] ? (m_buf ^ 1) : 0;
            if (m_ctrl[0] && (!m_ctrl[1] || m_buf == 1)) m_ctrl = m_ctrl & 16'h7FFF;
            m_elem = 0; m_buf = nb; m_addr = (nb != 0) ? m_b : m_a;
         end else begin
            m_elem++;
            if (am == 0) m_addr = (m_addr + (m_ctrl[14] ? 1 : 2)) & 16'hFFFF;
         end
      end
      req = (r != 0); req_addr = 16'(ra);
      @(posedge clk); @(negedge clk);
      req = 1'b0;
      chk({ctx, " R2 cmd_valid"}, 32'(cmd_valid), e_v);
      chk({ctx, " R6/R7 irq"}, 32'(irq), e_irq);
      chk({ctx, " R10/R11 ctrl_rd"}, 32'(ctrl_rd), m_ctrl);
      if (e_v != 0) begin
         chk({ctx, " R3 dir"}, 32'(cmd_ram_to_per), m_ctrl[13] ? 1 : 0);
         chk({ctx, " R3 byte"}, 32'(cmd_byte), m_ctrl[14] ? 1 : 0);
         chk({ctx, " R3 per_addr"}, 32'(cmd_per_addr), m_per);
         chk({ctx, " R4/R8/R9 ram_addr"}, 32'(cmd_ram_addr), e_ram);
         chk({ctx, " R5 null"}, 32'(cmd_null_per), (m_ctrl[11] && !m_ctrl[13]) ? 1 : 0);
      end
   endtask

   task automatic setup(int a, int b, int per, int cnt, int ctrl);
      wcfg(1, a); wcfg(2, b); wcfg(3, per); wcfg(4, cnt); wcfg(0, ctrl);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset ctrl_rd", 32'(ctrl_rd), 0);
      chk("R1 reset cmd_valid", 32'(cmd_valid), 0);
      chk("R1 reset irq", 32'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      wcfg(0, 16'hFFFF);
      chk("R1 unimplemented bits", 32'(ctrl_rd), 16'hF833);
      wcfg(0, 0);

      // R2 disabled channel ignores requests
      setup(16'h40, 16'h80, 12'h123, 3, 16'h0000);
      for (int i = 0; i < 3; i++) cyc(1, 0, "R2 disabled");

      // R11 one-shot alternating, N=3, word, increment
      setup(16'h100, 16'h200, 12'h0AA, 2, 16'h8003);
      for (int i = 0; i < 8; i++) cyc(1, 0, "R11 oneshot-pp");
      chk("R11 enable cleared", 32'(ctrl_rd[15]), 0);

      // R10 one-shot single buffer, byte, N=2
      setup(16'h300, 16'h400, 12'h011, 1, 16'hC001);
      for (int i = 0; i < 4; i++) cyc(1, 0, "R10 oneshot");
      chk("R10 enable cleared", 32'(ctrl_rd[15]), 0);

      // R7 half interrupt, N=1 and N=5
      setup(16'h500, 16'h600, 12'h022, 0, 16'h9000);
      for (int i = 0; i < 3; i++) cyc(1, 0, "R7 half N=1");
      setup(16'h500, 16'h600, 12'h022, 4, 16'h9000);
      for (int i = 0; i < 10; i++) cyc(1, 0, "R7 half N=5");

      // R6 full-block interrupt with gaps in requests, N=4
      setup(16'h700, 16'h800, 12'h033, 3, 16'h8000);
      for (int i = 0; i < 10; i++) cyc(i % 3 != 2, 0, "R6 full");

      // R12 restart in the middle of a block
      setup(16'h900, 16'hA00, 12'h044, 5, 16'h8000);
      for (int i = 0; i < 3; i++) cyc(1, 0, "R12 pre");
      wcfg(0, 16'h8000);
      for (int i = 0; i < 7; i++) cyc(1, 0, "R12 post");

      // R5 null write in both directions
      setup(16'hB00, 16'hC00, 12'h055, 2, 16'h8800);
      for (int i = 0; i < 3; i++) cyc(1, 0, "R5 null p2r");
      wcfg(0, 16'hA800);
      for (int i = 0; i < 3; i++) cyc(1, 0, "R5 null r2p");

      // R8 continuous, R9 continuous alternating
      setup(16'hD00, 16'hE00, 12'h066, 1, 16'h8000);
      for (int i = 0; i < 6; i++) cyc(1, 0, "R8 continuous");
      setup(16'hD00, 16'hE00, 12'h066, 1, 16'h8002);
      for (int i = 0; i < 8; i++) cyc(1, 0, "R9 continuous-pp");

      // R4 fixed, peripheral-supplied, reserved addressing
      setup(16'hF00, 16'hF80, 12'h077, 3, 16'h8010);
      for (int i = 0; i < 5; i++) cyc(1, 0, "R4 fixed");
      wcfg(0, 16'h8020);
      for (int i = 0; i < 5; i++) cyc(1, int'($urandom & 16'hFFFF), "R4 periph");
      wcfg(0, 16'h8030);
      for (int i = 0; i < 5; i++) cyc(1, 0, "R4 reserved");

      // random configurations
      for (int k = 0; k < 40; k++) begin
         setup(int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF),
               int'($urandom & 12'hFFF), int'($urandom % 8),
               int'(($urandom & 16'hF833) | 16'h8000));
         for (int i = 0; i < 30; i++)
            cyc(($urandom % 3) != 0 ? 1 : 0, int'($urandom & 16'hFFFF), "rand");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule